// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level page table held in main memory. A requester hands over an address and a read/write flag through a valid/ready handshake. The walker checks the page number against a table limit, then fetches one word from the outer table and one word from the inner table over a simple request/response memory port. At each level it inspects the entry's present and write-permit bits. It finishes with either a physical address or a two-bit fault code plus the level at which the walk stopped.

Only one walk is in flight at a time. The table root address and the page limit are sampled when a request is accepted, so software may change them while a walk is running. Each successful walk also raises a one-cycle fill record that carries the page number, the frame and the combined write permission, for loading into a translation cache beside the walker.

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address splits as outer index [31:22], inner index [21:12] and offset [11:0]. The first memory read goes to `pt_base + outer_index*4`. Both `pt_base` and `pt_limit` are sampled in the cycle the request is accepted.
- R2: The second memory read goes to `{outer_entry[31:12], 12'h000} + inner_index*4`.
- R3: If the page number `vaddr[31:12]` is greater than or equal to `pt_limit`, the walk ends with fault code 01 at level 0 and makes no memory read.
- R4: An entry whose bit 0 (present) is clear ends the walk with fault code 10. The level is 0 for the outer entry and 1 for the inner entry, and no further read is made. Presence is tested before permission.
- R5: A write request that meets an entry whose bit 1 (write-permit) is clear ends the walk with fault code 11 at that entry's level. A read request ignores bit 1.
- R6: On success the fault code is 00 and `res_paddr` is `{inner_entry[31:12], vaddr[11:0]}`. On any fault `res_paddr` is zero. Entry bits 11:2 have no effect.
- R7: `req_ready` is high only when the walker is idle. No new request is taken from acceptance until the result has been consumed with `res_ready`.
- R8: A successful walk raises `fill_valid` for exactly one cycle, in the first cycle `res_valid` is high. The record carries `fill_vpn = vaddr[31:12]`, `fill_frame = inner_entry[31:12]` and `fill_writable` = the AND of both write-permit bits. A faulting walk raises no fill.
- R9: A memory request keeps its address stable until `mem_req_ready` accepts it. A result keeps its fields stable until `res_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| pt_base | input | 32 | Byte address of the outer table |
| pt_limit | input | 20 | Number of legal virtual pages |
| mem_req_valid | output | 1 | Memory word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_fault | output | 2 | 00 ok, 01 bounds, 10 not present, 11 write-protected |
| res_level | output | 1 | Level where the fault arose (0 outer, 1 inner) |
| res_paddr | output | 32 | Physical address, zero on fault |
| fill_valid | output | 1 | One-cycle translation cache fill strobe |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_frame | output | 20 | Physical frame of the fill |
| fill_writable | output | 1 | Page writable through both levels |

## Verification
The bench aims at the edge of the limit check, with the page number equal to the limit and one below it, and with a zero limit. An off-by-one comparator would grant or fault the wrong page there, and a walker that checks too late would show a stray memory read. It pairs an absent entry with a write to a read-only entry, so that swapping the order of the two tests shows up as the wrong fault code. It sets faults at each level to catch a wrong level bit, or a second read issued after an outer fault. It puts random values in the reserved entry bits and scrambles the request, root and limit inputs while a walk runs. A walker that decoded the reserved bits, accepted a second request or sampled the root late would then read the wrong address or give a wrong result.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int LEVELS  = 2;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int ENT_W   = 32;
    localparam int RSV_W   = ENT_W - FRAME_W - 2;
    localparam int ENT_SH  = $clog2(ENT_W / 8);

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_BOUNDS  = 2'b01,
        FLT_INVALID = 2'b10,
        FLT_PROT    = 2'b11
    } fault_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSV_W-1:0]   rsvd;
        logic               wr_ok;
        logic               present;
    } pte_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OREQ,
        S_OWAIT,
        S_IREQ,
        S_IWAIT,
        S_DONE
    } walk_state_e;

    function automatic logic [VA_W-1:0] slot_addr(input logic [VA_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
        return base + {{(VA_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] frame_base(input logic [FRAME_W-1:0] f);
        return {f, {OFF_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pgwalk_addr_split.sv
module pgwalk_addr_split
    import pgwalk_pkg::*;
#(
    parameter int VPNW = VPN_W,
    parameter int IDXW = IDX_W,
    parameter int LVLS = LEVELS
) (
    input  logic [VPNW-1:0]            vpn,
    input  logic [VPNW-1:0]            limit,
    output logic [LVLS-1:0][IDXW-1:0]  idx,
    output logic                       in_range
);

    // index 0 is the outer (most significant) slice
    generate
        for (genvar l = 0; l < LVLS; l++) begin : g_lvl
            assign idx[l] = vpn[VPNW-1-l*IDXW -: IDXW];
        end
    endgenerate

    assign in_range = (vpn < limit);

endmodule

// File: rtl/pgwalk_entry_check.sv
module pgwalk_entry_check
    import pgwalk_pkg::*;
(
    input  pte_t   pte,
    input  logic   is_write,
    output fault_e verdict
);

    // presence wins over permission
    always_comb begin
        if (!pte.present)
            verdict = FLT_INVALID;
        else if (is_write && !pte.wr_ok)
            verdict = FLT_PROT;
        else
            verdict = FLT_NONE;
    end

    logic unused_bits;
    assign unused_bits = ^{pte.frame, pte.rsvd};

endmodule

// File: rtl/pgwalk_seq.sv
module pgwalk_seq
    import pgwalk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [IDX_W-1:0]   outer_idx,
    input  logic [IDX_W-1:0]   inner_idx,
    input  logic               in_range,
    input  logic [VA_W-1:0]    base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [VA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  pte_t               rsp_pte,
    input  fault_e             verdict,
    output logic               chk_write,
    output logic               res_valid,
    input  logic               res_ready,
    output fault_e             res_fault,
    output logic               res_level,
    output logic [VA_W-1:0]    res_paddr,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [FRAME_W-1:0] fill_frame,
    output logic               fill_writable
);

    walk_state_e         state_q;
    logic [VA_W-1:0]     addr_q;
    logic [IDX_W-1:0]    iidx_q;
    logic [VPN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]    off_q;
    logic                wr_q;
    logic                wp_q;
    logic                lvl_q;
    logic                fill_q;
    fault_e              fault_q;
    logic [FRAME_W-1:0]  frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            iidx_q  <= '0;
            vpn_q   <= '0;
            off_q   <= '0;
            wr_q    <= 1'b0;
            wp_q    <= 1'b0;
            lvl_q   <= 1'b0;
            fill_q  <= 1'b0;
            fault_q <= FLT_NONE;
            frame_q <= '0;
        end else begin
            fill_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        vpn_q   <= req_vpn;
                        off_q   <= req_off;
                        wr_q    <= req_write;
                        iidx_q  <= inner_idx;
                        frame_q <= '0;
                        lvl_q   <= 1'b0;
                        if (!in_range) begin
                            fault_q <= FLT_BOUNDS;
                            state_q <= S_DONE;
                        end else begin
                            fault_q <= FLT_NONE;
                            addr_q  <= slot_addr(base, outer_idx);
                            state_q <= S_OREQ;
                        end
                    end
                end
                S_OREQ: begin
                    if (mem_req_ready) state_q <= S_OWAIT;
                end
                S_OWAIT: begin
                    if (mem_rsp_valid) begin
                        if (verdict != FLT_NONE) begin
                            fault_q <= verdict;
                            lvl_q   <= 1'b0;
                            state_q <= S_DONE;
                        end else begin
                            addr_q  <= slot_addr(frame_base(rsp_pte.frame), iidx_q);
                            wp_q    <= rsp_pte.wr_ok;
                            state_q <= S_IREQ;
                        end
                    end
                end
                S_IREQ: begin
                    if (mem_req_ready) state_q <= S_IWAIT;
                end
                S_IWAIT: begin
                    if (mem_rsp_valid) begin
                        lvl_q <= 1'b1;
                        if (verdict != FLT_NONE) begin
                            fault_q <= verdict;
                        end else begin
                            frame_q <= rsp_pte.frame;
                            wp_q    <= wp_q & rsp_pte.wr_ok;
                            fill_q  <= 1'b1;
                        end
                        state_q <= S_DONE;
                    end
                end
                S_DONE: begin
                    if (res_ready) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == S_IDLE);
    assign mem_req_valid = (state_q == S_OREQ) || (state_q == S_IREQ);
    assign mem_req_addr  = addr_q;
    assign chk_write     = wr_q;
    assign res_valid     = (state_q == S_DONE);
    assign res_fault     = fault_q;
    assign res_level     = lvl_q;
    assign res_paddr     = (fault_q == FLT_NONE) ? {frame_q, off_q} : '0;
    assign fill_valid    = fill_q;
    assign fill_vpn      = vpn_q;
    assign fill_frame    = frame_q;
    assign fill_writable = wp_q;

    // R7: idle walker has nothing outstanding
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !res_valid));

    // R9: a pending memory read does not move
    p_memreq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: an unconsumed result does not move
    p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_fault) && $stable(res_paddr) && $stable(res_level)));

    // R8: fills only accompany a fresh successful result
    p_fill_success_r8: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (res_valid && res_fault == FLT_NONE && !$past(res_valid)));

    // R3: bounds faults are always reported at the outer level
    p_bounds_outer_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault == FLT_BOUNDS) |-> !res_level);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic [VA_W-1:0]    pt_base,
    input  logic [VPN_W-1:0]   pt_limit,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [VA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [1:0]         res_fault,
    output logic               res_level,
    output logic [VA_W-1:0]    res_paddr,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [FRAME_W-1:0] fill_frame,
    output logic               fill_writable
);

    logic [LEVELS-1:0][IDX_W-1:0] idx;
    logic   in_range;
    logic   chk_write;
    pte_t   rsp_pte;
    fault_e verdict;
    fault_e fault_w;

    assign rsp_pte   = pte_t'(mem_rsp_data);
    assign res_fault = fault_w;

    pgwalk_addr_split u_split (
        .vpn      (req_vaddr[VA_W-1:OFF_W]),
        .limit    (pt_limit),
        .idx      (idx),
        .in_range (in_range)
    );

    pgwalk_entry_check u_check (
        .pte      (rsp_pte),
        .is_write (chk_write),
        .verdict  (verdict)
    );

    pgwalk_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_off       (req_vaddr[OFF_W-1:0]),
        .req_vpn       (req_vaddr[VA_W-1:OFF_W]),
        .outer_idx     (idx[0]),
        .inner_idx     (idx[1]),
        .in_range      (in_range),
        .base          (pt_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_pte       (rsp_pte),
        .verdict       (verdict),
        .chk_write     (chk_write),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_fault     (fault_w),
        .res_level     (res_level),
        .res_paddr     (res_paddr),
        .fill_valid    (fill_valid),
        .fill_vpn      (fill_vpn),
        .fill_frame    (fill_frame),
        .fill_writable (fill_writable)
    );

endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] pt_base = '0;
    logic [19:0] pt_limit = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [1:0]  res_fault;
    logic        res_level;
    logic [31:0] res_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn;
    logic [19:0] fill_frame;
    logic        fill_writable;

    always #2.5 clk = ~clk;

    pgwalk_top dut_i (.*);

    int total = 0;
    int bad   = 0;

    // memory model knobs
    logic        k_ov, k_ow, k_iv, k_iw;
    logic [19:0] k_ibase, k_frame;
    logic [31:0] exp_oaddr, exp_iaddr;
    int          nreq = 0;
    int          addr_err = 0;
    logic [31:0] bad_addr = '0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [31:0] pdata = '0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
        end else begin
            logic r;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (pcnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pdata;
                    pend = 1'b0;
                end else begin
                    pcnt--;
                end
            end
            r = ($urandom % 3) != 0;
            if (mem_req_valid && r && !pend) begin
                logic [31:0] ea;
                ea = (nreq == 0) ? exp_oaddr : exp_iaddr;
                if (mem_req_addr != ea) begin
                    addr_err++;
                    bad_addr = mem_req_addr;
                end
                if (nreq == 0)
                    pdata = {k_ibase, 10'($urandom), k_ow, k_ov};
                else
                    pdata = {k_frame, 10'($urandom), k_iw, k_iv};
                nreq++;
                pend = 1'b1;
                pcnt = $urandom % 3;
            end
            mem_req_ready = r;
        end
    end

    task automatic walk(input logic [31:0] v, input logic w, input logic [31:0] base,
                        input logic [19:0] lim, input logic ov, input logic ow,
                        input logic iv, input logic iw, input logic [19:0] ib,
                        input logic [19:0] fr, input string tag);
        logic [1:0]  e_flt;
        logic        e_lvl;
        logic [31:0] e_pa;
        int          e_reads;
        int          busy_viol;
        int          cyc;
        int          hold;
        logic [1:0]  s_flt;
        logic [31:0] s_pa;
        logic        s_lvl;

        k_ov = ov; k_ow = ow; k_iv = iv; k_iw = iw; k_ibase = ib; k_frame = fr;
        exp_oaddr = base + {20'd0, v[31:22], 2'b00};
        exp_iaddr = {ib, 12'h000} + {20'd0, v[21:12], 2'b00};
        nreq = 0; addr_err = 0;

        e_pa = 32'h0; e_lvl = 1'b0;
        if (v[31:12] >= lim) begin e_flt = 2'b01; e_reads = 0; end
        else if (!ov)         begin e_flt = 2'b10; e_reads = 1; end
        else if (w && !ow)    begin e_flt = 2'b11; e_reads = 1; end
        else if (!iv)         begin e_flt = 2'b10; e_lvl = 1'b1; e_reads = 2; end
        else if (w && !iw)    begin e_flt = 2'b11; e_lvl = 1'b1; e_reads = 2; end
        else begin e_flt = 2'b00; e_reads = 2; e_pa = {fr, v[11:0]}; end

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_write = w; pt_base = base; pt_limit = lim;
        @(negedge clk);
        // keep a second request pending and scramble sampled inputs
        req_vaddr = $urandom; req_write = ~w; pt_base = $urandom; pt_limit = 20'($urandom);
        busy_viol = 0; cyc = 0;
        while (!res_valid && cyc < 200) begin
            if (req_ready) busy_viol++;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(res_valid, {tag, " R7 result arrives"}, 32'(res_valid), 1);
        chk(busy_viol == 0, {tag, " R7 busy refuses requests"}, busy_viol, 0);
        chk(res_fault == e_flt, {tag, " R3/R4/R5 fault code"}, res_fault, e_flt);
        if (e_flt != 2'b00)
            chk(res_level == e_lvl, {tag, " R4/R5 fault level"}, res_level, e_lvl);
        chk(res_paddr == e_pa, {tag, " R6 paddr"}, res_paddr, e_pa);
        chk(fill_valid == (e_flt == 2'b00), {tag, " R8 fill strobe"}, fill_valid, (e_flt == 2'b00));
        if (e_flt == 2'b00) begin
            chk(fill_vpn == v[31:12], {tag, " R8 fill vpn"}, fill_vpn, v[31:12]);
            chk(fill_frame == fr, {tag, " R8 fill frame"}, fill_frame, fr);
            chk(fill_writable == (ow & iw), {tag, " R8 fill writable"}, fill_writable, (ow & iw));
        end
        chk(nreq == e_reads, {tag, " R3/R4 read count"}, nreq, e_reads);
        chk(addr_err == 0, {tag, " R1/R2 read address"}, bad_addr, exp_oaddr);
        s_flt = res_fault; s_pa = res_paddr; s_lvl = res_level;
        hold = $urandom % 3;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(res_valid && res_fault == s_flt && res_paddr == s_pa && res_level == s_lvl,
                {tag, " R9 result held"}, res_paddr, s_pa);
            chk(!fill_valid, {tag, " R8 single fill pulse"}, fill_valid, 0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(req_ready && !res_valid, {tag, " R7 idle after consume"}, req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "reset R7 ready", req_ready, 1);
        chk(!mem_req_valid && !res_valid && !fill_valid, "reset R9 quiet",
            {mem_req_valid, res_valid, fill_valid}, 0);

        // directed corner cases
        walk(32'h0040_3ABC, 1'b0, 32'h0010_0000, 20'hFFFFF, 1,1,1,1, 20'h00123, 20'hABCDE, "R6 read ok");
        walk(32'hFFC0_1004, 1'b1, 32'h0020_0400, 20'hFFFFF, 1,1,1,1, 20'h00456, 20'h13579, "R1 R2 write ok");
        walk(32'h0000_5FFF, 1'b0, 32'h0010_0000, 20'h00005, 1,1,1,1, 20'h00001, 20'h00002, "R3 vpn==limit");
        walk(32'h0000_4FFF, 1'b0, 32'h0010_0000, 20'h00005, 1,1,1,1, 20'h00001, 20'h00002, "R3 vpn==limit-1");
        walk(32'h0000_0000, 1'b0, 32'h0010_0000, 20'h00000, 1,1,1,1, 20'h00001, 20'h00002, "R3 zero limit");
        walk(32'h1234_5678, 1'b0, 32'h0010_0000, 20'hFFFFF, 0,1,1,1, 20'h00001, 20'h00002, "R4 outer absent");
        walk(32'h1234_5678, 1'b1, 32'h0010_0000, 20'hFFFFF, 0,0,1,1, 20'h00001, 20'h00002, "R4 absent beats ro");
        walk(32'h1234_5678, 1'b1, 32'h0010_0000, 20'hFFFFF, 1,0,1,1, 20'h00001, 20'h00002, "R5 outer ro write");
        walk(32'h8765_4321, 1'b0, 32'h0010_0000, 20'hFFFFF, 1,1,0,1, 20'h00777, 20'h00002, "R4 inner absent");
        walk(32'h8765_4321, 1'b1, 32'h0010_0000, 20'hFFFFF, 1,1,1,0, 20'h00777, 20'h00002, "R5 inner ro write");
        walk(32'h8765_4321, 1'b0, 32'h0010_0000, 20'hFFFFF, 1,0,1,0, 20'h00777, 20'h0BEEF, "R5 read of ro page");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [31:0] v;
            logic [19:0] lim;
            v = $urandom;
            case ($urandom % 4)
                0: lim = v[31:12];
                1: lim = v[31:12] + 20'd1;
                2: lim = 20'($urandom);
                default: lim = 20'hFFFFF;
            endcase
            walk(v, 1'($urandom), {$urandom} & 32'hFFFF_FFFC, lim,
                 ($urandom % 5) != 0, ($urandom % 3) != 0,
                 ($urandom % 5) != 0, ($urandom % 3) != 0,
                 20'($urandom), 20'($urandom), "R1 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule